// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Clear

This block holds a 15-bit up-counter that advances on a slow-clock enable pulse. The pulse is synchronous to the fast bus clock. The counter serves one of two purposes. In watchdog mode it issues a one-cycle reset request when the selected terminal count is reached. In timer mode it issues a one-cycle interrupt at the same point. In both modes the counter then wraps to zero. An 8-bit control register sets enable, mode and interval, and it carries a write-only key field.

Software keeps the watchdog alive by writing a two-step key. The first value arms the clear. The second value, written within a bounded window of fast-clock cycles, zeroes the count. Once the watchdog is running it cannot be switched off or moved to timer mode. A sleep input stops the reset request while it is asserted, and the counter keeps counting and wrapping during sleep. A timeout that occurs during sleep is remembered, and the reset request is issued as soon as the sleep input falls.

Top module: `wdt_keyed`

## Requirements
- R1: After reset `rd_data_o` is 0x00, `irq_o` and `rst_req_o` are low, and the counter is stopped.
- R2: A write sets the control fields: enable at bit 3, mode at bit 2 (0 = watchdog, 1 = timer) and interval at bits 1:0. `rd_data_o` returns {4'b0000, enable, mode, interval}, so the key field (bits 7:4) always reads as zero.
- R3: Writing 1 to bit 3 starts the counter, which then advances once per `tick_i`. In timer mode, writing 0 to bit 3 stops the counter and keeps its value.
- R4: While the block is enabled in watchdog mode, writing 0 to bit 3 is ignored and writes to bit 2 are ignored. Only reset returns the block to the disabled state.
- R5: Interval codes 00, 01, 10 and 11 select 32768, 8192, 512 and 64 ticks. The event occurs on the tick that completes that many counts from zero.
- R6: In timer mode, reaching terminal count drives `irq_o` high for exactly one cycle, wraps the counter to zero and leaves `rst_req_o` low.
- R7: In watchdog mode with `sleep_i` low, reaching terminal count drives `rst_req_o` high for one cycle, wraps the counter to zero and leaves `irq_o` low.
- R8: The count is reloaded with zero when key 0xA is written to bits 7:4 and key 0x5 follows within KEY_WIN cycles. The 0x5 write may come at most KEY_WIN clock edges after the 0xA write.
- R9: A 0x5 written too late, a 0x5 written before 0xA, or any other key value written in between leaves the count unchanged.
- R10: Key writes have no effect while the enable bit is 0.
- R11: While `sleep_i` is high, a watchdog terminal count does not assert `rst_req_o`, and the counter wraps and keeps counting.
- R12: If a watchdog terminal count occurred during sleep, `rst_req_o` pulses in the first cycle after `sleep_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow-clock enable pulse, one cycle wide |
| sleep_i | input | 1 | Low-power state; blocks the reset request |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data: key[7:4], enable[3], mode[2], interval[1:0] |
| rd_data_o | output | 8 | Control register read value, with the key field read as zero |
| irq_o | output | 1 | Interval interrupt pulse (timer mode) |
| rst_req_o | output | 1 | Reset request pulse (watchdog mode) |

## Verification
The counter is not visible at the ports. A wrong count or a lost clear therefore shows up as an event that arrives too early or too late, measured in cycles from the last enable or clear write. For this reason every key-sequence and enable case is checked by the exact cycle number of the next event. A window counter that is off by one changes the result of the boundary pair (the 0x5 write exactly at the window limit, then one cycle later) in that same measurement. A pending sleep timeout that is lost or set wrongly shows up within one cycle of wakeup.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    MODE_WDOG  = 1'b0,
    MODE_TIMER = 1'b1
  } wmode_e;

  localparam logic [3:0] KEY_ARM  = 4'hA;
  localparam logic [3:0] KEY_FIRE = 4'h5;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_fields,
  output logic       en_o,
  output wmode_e     mode_o,
  output logic [1:0] intv_o
);
  logic   en_q;
  wmode_e mode_q;
  logic [1:0] intv_q;
  logic   locked;

  assign locked = en_q && (mode_q == MODE_WDOG);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= MODE_WDOG;
      intv_q <= 2'b00;
    end else if (wr_en) begin
      intv_q <= wr_fields[1:0];
      if (!locked) mode_q <= wmode_e'(wr_fields[2]);
      if (wr_fields[3]) en_q <= 1'b1;
      else if (mode_q == MODE_TIMER) en_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign intv_o = intv_q;

  // R4: a running watchdog stays running and stays in watchdog mode
  assert_wd_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (en_q && mode_q == MODE_WDOG) |=> (en_q && mode_q == MODE_WDOG));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int KEY_WIN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] key_i,
  input  logic       en_i,
  output logic       clr_o
);
  localparam int WIN_W = $clog2(KEY_WIN + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(KEY_WIN - 1);

  logic             armed_q;
  logic [WIN_W-1:0] win_q;
  logic             key_wr;

  assign key_wr = wr_en && en_i;
  assign clr_o  = key_wr && armed_q && (key_i == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else if (key_wr) begin
      armed_q <= (key_i == KEY_ARM);
      win_q   <= '0;
    end else if (armed_q) begin
      if (win_q == WIN_LAST) armed_q <= 1'b0;
      else                   win_q   <= win_q + 1'b1;
    end
  end

  // R8: arming only ever follows an enabled write of the first key
  assert_arm_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(wr_en && en_i && key_i == KEY_ARM));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int TC0   = 32768,
  parameter int TC1   = 8192,
  parameter int TC2   = 512,
  parameter int TC3   = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       en_i,
  input  wmode_e     mode_i,
  input  logic [1:0] intv_i,
  input  logic       sleep_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'(TC0 - 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(TC1 - 1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(TC2 - 1);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'(TC3 - 1);

  logic [CNT_W-1:0] cnt_q, lim;
  logic advance, hit, wd_hit;
  logic irq_q, rst_q, pend_q;

  always_comb begin
    case (intv_i)
      2'b00:   lim = LIM0;
      2'b01:   lim = LIM1;
      2'b10:   lim = LIM2;
      default: lim = LIM3;
    endcase
  end

  assign advance = tick_i && en_i && !clr_i;
  assign hit     = advance && (cnt_q >= lim);
  assign wd_hit  = hit && (mode_i == MODE_WDOG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q <= hit && (mode_i == MODE_TIMER);
      rst_q <= 1'b0;
      if (clr_i)        cnt_q <= '0;
      else if (hit)     cnt_q <= '0;
      else if (advance) cnt_q <= cnt_q + 1'b1;
      if (sleep_i) begin
        if (wd_hit) pend_q <= 1'b1;
      end else if (pend_q || wd_hit) begin
        rst_q  <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  // R6: the interrupt is a single-cycle pulse
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R7: the two event outputs never fire together
  assert_event_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && rst_q));
  // R11: no reset request is issued for a cycle in which sleep was high
  assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> !$past(sleep_i));
  // R8: a keyed clear leaves the count at zero
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int TC0     = 32768,
  parameter int TC1     = 8192,
  parameter int TC2     = 512,
  parameter int TC3     = 64,
  parameter int KEY_WIN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       sleep_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic       en;
  wmode_e     mode;
  logic [1:0] intv;
  logic       clr;

  wdt_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_i),
    .wr_fields (wr_data_i[3:0]),
    .en_o      (en),
    .mode_o    (mode),
    .intv_o    (intv)
  );

  wdt_key_seq #(.KEY_WIN(KEY_WIN)) u_key (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en_i),
    .key_i (wr_data_i[7:4]),
    .en_i  (en),
    .clr_o (clr)
  );

  wdt_counter #(
    .CNT_W(CNT_W), .TC0(TC0), .TC1(TC1), .TC2(TC2), .TC3(TC3)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .en_i      (en),
    .mode_i    (mode),
    .intv_i    (intv),
    .sleep_i   (sleep_i),
    .clr_i     (clr),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  assign rd_data_o = {4'b0000, en, mode, intv};
endmodule

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int KW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic sleep = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq, rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  wdt_keyed #(.KEY_WIN(KW)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .sleep_i(sleep),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  // {reset first, write data, expected read value}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h06, 8'h06},   // R2 fields while disabled
    {1'b0, 8'h0F, 8'h0F},   // R3 enable in timer mode
    {1'b0, 8'h04, 8'h04},   // R3 disable in timer mode
    {1'b0, 8'hF3, 8'h03},   // R2 key field reads zero
    {1'b0, 8'h09, 8'h09},   // R3 enable watchdog
    {1'b0, 8'h00, 8'h08},   // R4 disable ignored
    {1'b0, 8'h0E, 8'h0A},   // R4 mode write ignored
    {1'b1, 8'h00, 8'h00}    // R1 reset clears
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // cycles until the chosen output rises (0 = none within limit)
  task automatic measure(input bit use_rst, input int limit,
                         output int n, output bit other);
    n = 0;
    other = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (use_rst ? irq : rst_req) other = 1'b1;
      if (use_rst ? rst_req : irq) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    int n;
    bit oth;
    @(negedge clk);
    do_reset();
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 rst_req", int'(rst_req), 0);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][16]) do_reset();
      wr(VEC[i][15:8]);
      check($sformatf("R2/R3/R4 vector %0d", i), int'(rd_data), int'(VEC[i][7:0]));
    end

    tick = 1'b1;

    // R1: stopped after reset
    do_reset();
    measure(1'b0, 100, n, oth);
    check("R1 no irq while stopped", n, 0);

    // R6/R5 timer, interval 64
    do_reset();
    wr(8'h0F);
    measure(1'b0, 80, n, oth);
    check("R5 interval 11 = 64", n, 64);
    check("R6 no rst_req in timer mode", int'(oth), 0);
    @(negedge clk);
    check("R6 one-cycle irq", int'(irq), 0);
    measure(1'b0, 80, n, oth);
    check("R6 wrap to zero", n, 63);

    do_reset(); wr(8'h0E);
    measure(1'b0, 600, n, oth);
    check("R5 interval 10 = 512", n, 512);
    do_reset(); wr(8'h0D);
    measure(1'b0, 8300, n, oth);
    check("R5 interval 01 = 8192", n, 8192);
    do_reset(); wr(8'h0C);
    measure(1'b0, 33000, n, oth);
    check("R5 interval 00 = 32768", n, 32768);

    // R7 watchdog
    do_reset(); wr(8'h0B);
    measure(1'b1, 80, n, oth);
    check("R7 watchdog reset at 64", n, 64);
    check("R7 no irq in watchdog mode", int'(oth), 0);
    @(negedge clk);
    check("R7 one-cycle rst_req", int'(rst_req), 0);

    // R8 immediate key pair
    do_reset(); wr(8'h0B); idle(2);
    wr(8'hAB); wr(8'h5B);
    measure(1'b1, 80, n, oth);
    check("R8 key clear", n, 64);
    // R8 second key at the window limit
    do_reset(); wr(8'h0B); idle(2);
    wr(8'hAB); idle(KW - 1); wr(8'h5B);
    measure(1'b1, 80, n, oth);
    check("R8 key at window edge", n, 64);
    // R9 one cycle too late
    do_reset(); wr(8'h0B); idle(2);
    wr(8'hAB); idle(KW); wr(8'h5B);
    measure(1'b1, 80, n, oth);
    check("R9 late key ignored", n, 64 - (2 + KW + 2));
    // R9 reversed order
    do_reset(); wr(8'h0B); idle(2);
    wr(8'h5B); wr(8'hAB);
    measure(1'b1, 80, n, oth);
    check("R9 reversed keys ignored", n, 60);
    // R9 other value between
    do_reset(); wr(8'h0B); idle(2);
    wr(8'hAB); wr(8'h3B); wr(8'h5B);
    measure(1'b1, 80, n, oth);
    check("R9 interrupted keys ignored", n, 59);

    // R10 keys while disabled; R3 stop holds count
    do_reset(); wr(8'h0F); idle(10);
    wr(8'h07); wr(8'hA7); wr(8'h57); wr(8'h0F);
    measure(1'b0, 80, n, oth);
    check("R10/R3 disabled keys ignored, count held", n, 53);

    // R11/R12 sleep
    do_reset();
    sleep = 1'b1;
    wr(8'h0B);
    measure(1'b1, 100, n, oth);
    check("R11 no reset during sleep", n, 0);
    sleep = 1'b0;
    measure(1'b1, 80, n, oth);
    check("R12 reset at wakeup", n, 1);
    measure(1'b1, 80, n, oth);
    check("R11 counter wrapped during sleep", n, 27);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule